// File: doc/BRIEF.md
# Byte-Register Execute Unit with Flag Writeback

This block is the register-to-register execute stage of a small 8-bit interpreter-style machine. It holds sixteen 8-bit general registers, numbered 0 to 15. Register 15 doubles as the flag register. A 16-bit opcode arrives with a one-cycle valid strobe. The block captures both source operands and the decoded operation on the acceptance edge. On the following edge it commits the result and, where the operation defines one, the flag.

Two opcode groups are executed. Group `8XYN` covers register moves, bitwise logic, add, the two subtract forms and single-bit shifts. Group `CXNN` loads a register with a pseudo-random byte masked by an immediate. The flag write is ordered after the result write. When the destination is register 15, it ends up holding the flag alone. Because operands are captured before anything is written, an operation whose two sources are the same register still produces the correct flag. Two combinational read ports let the surrounding logic, or a bench, observe any register.

Top module: `byte_alu_exec`

## Requirements
- R1: A synchronous active-low reset clears all sixteen registers to 0x00, holds `done` and `illegal` low, and loads the random-byte generator with 0x01.
- R2: An opcode is accepted on a rising edge where `op_valid` is high and no opcode is in flight. Its register writes take effect on the next rising edge. `done` is high for exactly the one cycle after that edge.
- R3: For group 8 with N=0, 1, 2 or 3, register X becomes Y, X OR Y, X AND Y or X XOR Y respectively. Register 15 is not touched unless X is 15.
- R4: For N=4, X becomes (X+Y) mod 256, and register 15 becomes 1 if the true sum exceeds 255, else 0.
- R5: For N=5, X becomes (X−Y) mod 256, and the flag is 1 when X ≥ Y. For N=7, X becomes (Y−X) mod 256, and the flag is 1 when Y ≥ X. In both cases the flag is 0 on underflow.
- R6: For N=6, X is shifted right by one and the flag is the old bit 0 of X. For N=0xE, X is shifted left by one and the flag is the old bit 7 of X. Register Y is not used.
- R7: The flag write wins over the result write. After a flag-setting operation with X=15, register 15 holds only 0x00 or 0x01. For example, register 15 = 0x84 and register 3 = 0x68 with opcode 0x8F34 leaves 0x00, and register 15 = 0x83 with opcode 0x8FF6 leaves 0x01.
- R8: Flags are computed from operand values captured before any write. With register 3 = 0xB4, opcode 0x8334 leaves register 3 = 0x68 and register 15 = 0x01.
- R9: For `CXNN`, X becomes the random byte AND NN. The random byte is the generator state, or 0xFF when `rnd_force_ones` is high at acceptance. The state is an 8-bit shift register that moves left by one, with new bit 0 = b7^b5^b4^b3. It advances exactly once per committed `CXNN`, so its nonzero states are all reached, 0xFF among them.
- R10: Group 8 with N in {8,9,A,B,C,D,F}, and any opcode whose top nibble is neither 8 nor C, changes no register. `illegal` is then high together with `done`.
- R11: `op_valid` in the cycle right after an acceptance is ignored. No second opcode is executed from it.
- R12: Read ports `rd_a_data` and `rd_b_data` combinationally show the current contents of the registers addressed by `rd_a_addr` and `rd_b_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 16 | Opcode to execute |
| rnd_force_ones | input | 1 | Forces the random byte to 0xFF for a CXNN |
| rd_a_addr | input | 4 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_addr | input | 4 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| done | output | 1 | One-cycle pulse after each commit |
| illegal | output | 1 | Pulses with done for an undefined opcode |

## Verification
The bound checker watches several properties on every cycle:
- the one-cycle shape of `done` and of the in-flight stage,
- `illegal` never appearing without `done`, and the flag register staying put on an illegal commit,
- the flag register holding only 0 or 1 after any flag-writing commit,
- the generator never reaching the all-zero state.

The arithmetic values themselves can only be shown by the bench scenarios:
- the carry and borrow flags,
- the flag overwriting the result when the destination is register 15,
- same-register operands,
- the masked random byte and the ignored back-to-back strobe.

The bench checks these against a register model of its own.

// File: rtl/alu_pkg.sv
// Shared types for the byte-register execute unit.
// Assumes 16-bit opcodes with a 4-bit group nibble in bits 15:12.
package alu_pkg;
    typedef enum logic [3:0] {
        OP_MOV, OP_OR, OP_AND, OP_XOR, OP_ADD, OP_SUB,
        OP_SHR, OP_SUBN, OP_SHL, OP_RND, OP_NOP
    } alu_op_e;

    localparam int OPC_W = 16;
endpackage

// File: rtl/alu_decode.sv
// Opcode decoder: splits an opcode into operation kind, register indices
// and immediate. Anything not defined maps to OP_NOP (R10).
// Assumes the group nibble, X, Y and N fields are each four bits wide.
module alu_decode
    import alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_op_e          op,
    output logic [3:0]       x_idx,
    output logic [3:0]       y_idx,
    output logic [7:0]       imm
);
    assign x_idx = opcode[11:8];
    assign y_idx = opcode[7:4];
    assign imm   = opcode[7:0];

    // Map group and low nibble to an operation kind.
    always_comb begin
        op = OP_NOP;
        if (opcode[15:12] == 4'hC) begin
            op = OP_RND;
        end else if (opcode[15:12] == 4'h8) begin
            unique case (opcode[3:0])
                4'h0:    op = OP_MOV;
                4'h1:    op = OP_OR;
                4'h2:    op = OP_AND;
                4'h3:    op = OP_XOR;
                4'h4:    op = OP_ADD;
                4'h5:    op = OP_SUB;
                4'h6:    op = OP_SHR;
                4'h7:    op = OP_SUBN;
                4'hE:    op = OP_SHL;
                default: op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/alu_compute.sv
// Combinational result and flag generation from captured operands.
// Assumes operands were latched before any write, so a==b aliasing is safe.
module alu_compute
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e            op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [DATA_W-1:0]  rnd,
    input  logic [DATA_W-1:0]  imm,
    output logic [DATA_W-1:0]  res,
    output logic               flag,
    output logic               wr_res,
    output logic               wr_flag
);
    logic [DATA_W:0] sum;
    assign sum = {1'b0, a} + {1'b0, b};

    // Select result, flag and which of the two writes apply.
    always_comb begin
        res     = '0;
        flag    = 1'b0;
        wr_res  = 1'b1;
        wr_flag = 1'b0;
        unique case (op)
            OP_MOV:  res = b;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_ADD:  begin res = sum[DATA_W-1:0]; flag = sum[DATA_W]; wr_flag = 1'b1; end
            OP_SUB:  begin res = a - b; flag = (a >= b); wr_flag = 1'b1; end
            OP_SUBN: begin res = b - a; flag = (b >= a); wr_flag = 1'b1; end
            OP_SHR:  begin res = a >> 1; flag = a[0]; wr_flag = 1'b1; end
            OP_SHL:  begin res = a << 1; flag = a[DATA_W-1]; wr_flag = 1'b1; end
            OP_RND:  res = rnd & imm;
            default: wr_res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_lfsr.sv
// Random-byte source: left-shifting feedback register, advanced on request.
// Assumes TAPS selects a maximal-length polynomial, so the state never hits zero.
module alu_lfsr #(
    parameter int          WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'hB8,
    parameter logic [WIDTH-1:0] SEED = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] state
);
    logic fb;
    assign fb = ^(state & TAPS);

    // Load seed on reset, otherwise shift once per step request.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= SEED;
        else if (step) state <= {state[WIDTH-2:0], fb};
    end
endmodule

// File: rtl/alu_regfile.sv
// Register file with one result write port, one flag write port into the
// top register (flag wins), two operand read ports and two observation ports.
// Assumes NUM_REGS is a power of two and the flag register is the last one.
module alu_regfile #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fl_en,
    input  logic              fl_bit,
    input  logic [AW-1:0]     ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [AW-1:0]     rb_addr,
    output logic [DATA_W-1:0] rb_data,
    input  logic [AW-1:0]     oa_addr,
    output logic [DATA_W-1:0] oa_data,
    input  logic [AW-1:0]     ob_addr,
    output logic [DATA_W-1:0] ob_data,
    output logic [DATA_W-1:0] flag_q
);
    localparam logic [AW-1:0] FLAG_IDX = AW'(NUM_REGS - 1);

    logic [DATA_W-1:0] regs [NUM_REGS];

    // Clear on reset; otherwise apply result write, then flag write over it (R7).
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (fl_en && (AW'(i) == FLAG_IDX))
                regs[i] <= {{(DATA_W-1){1'b0}}, fl_bit};
            else if (wr_en && (AW'(i) == wr_addr))
                regs[i] <= wr_data;
        end
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];
    assign oa_data = regs[oa_addr];
    assign ob_data = regs[ob_addr];
    assign flag_q  = regs[FLAG_IDX];
endmodule

// File: rtl/byte_alu_exec.sv
// Top of the byte-register execute unit. Stage 1 captures the decoded
// operation and both operands (R8); stage 2 commits result then flag and
// pulses done. Assumes op_valid is a strobe; one opcode is in flight at most.
module byte_alu_exec
    import alu_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          NUM_REGS  = 16,
    parameter logic [7:0]  LFSR_SEED = 8'h01,
    localparam int         AW        = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [15:0]       opcode,
    input  logic              rnd_force_ones,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              done,
    output logic              illegal
);
    alu_op_e           dec_op;
    logic [3:0]        dec_x, dec_y;
    logic [7:0]        dec_imm;
    logic [DATA_W-1:0] opa, opb, vf_q, lfsr_q;

    logic              s_valid;
    alu_op_e           s_op;
    logic [AW-1:0]     s_x;
    logic [DATA_W-1:0] s_a, s_b, s_rnd, s_imm;

    logic              accept;
    logic [DATA_W-1:0] cmp_res;
    logic              cmp_flag, cmp_wr_res, cmp_wr_flag;

    alu_decode u_dec (
        .opcode (opcode),
        .op     (dec_op),
        .x_idx  (dec_x),
        .y_idx  (dec_y),
        .imm    (dec_imm)
    );

    // R11: a strobe is taken only when nothing is in flight.
    assign accept = op_valid && !s_valid;

    // Capture operation, operands and random byte at acceptance (R8, R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_op    <= OP_NOP;
            s_x     <= '0;
            s_a     <= '0;
            s_b     <= '0;
            s_rnd   <= '0;
            s_imm   <= '0;
        end else begin
            s_valid <= accept;
            if (accept) begin
                s_op  <= dec_op;
                s_x   <= AW'(dec_x);
                s_a   <= opa;
                s_b   <= opb;
                s_rnd <= rnd_force_ones ? '1 : lfsr_q;
                s_imm <= DATA_W'(dec_imm);
            end
        end
    end

    alu_compute #(.DATA_W(DATA_W)) u_cmp (
        .op      (s_op),
        .a       (s_a),
        .b       (s_b),
        .rnd     (s_rnd),
        .imm     (s_imm),
        .res     (cmp_res),
        .flag    (cmp_flag),
        .wr_res  (cmp_wr_res),
        .wr_flag (cmp_wr_flag)
    );

    alu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (s_valid && cmp_wr_res),
        .wr_addr (s_x),
        .wr_data (cmp_res),
        .fl_en   (s_valid && cmp_wr_flag),
        .fl_bit  (cmp_flag),
        .ra_addr (AW'(dec_x)),
        .ra_data (opa),
        .rb_addr (AW'(dec_y)),
        .rb_data (opb),
        .oa_addr (rd_a_addr),
        .oa_data (rd_a_data),
        .ob_addr (rd_b_addr),
        .ob_data (rd_b_data),
        .flag_q  (vf_q)
    );

    alu_lfsr #(.WIDTH(DATA_W), .SEED(DATA_W'(LFSR_SEED))) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (s_valid && (s_op == OP_RND)),
        .state (lfsr_q)
    );

    // Completion pulse and illegal marker, one cycle after commit (R2, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= s_valid;
            illegal <= s_valid && (s_op == OP_NOP);
        end
    end
endmodule

// File: rtl/alu_checker.sv
// Protocol checker for byte_alu_exec, bound to every instance.
// Assumes rst_n is low from time zero until the first clean edges.
module alu_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              illegal,
    input logic              busy,
    input logic              flag_wr,
    input logic [DATA_W-1:0] vf,
    input logic [DATA_W-1:0] lfsr
);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> done);

    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !done);

    a_r10_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    a_r10_illegal_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable(vf));

    a_r11_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    a_r7_flag_only_bit: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> (vf <= DATA_W'(1)));

    a_r9_rng_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);
endmodule

bind byte_alu_exec alu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .illegal (illegal),
    .busy    (s_valid),
    .flag_wr (s_valid && cmp_wr_flag),
    .vf      (vf_q),
    .lfsr    (lfsr_q)
);

// File: tb/tb_byte_alu_exec.sv
// Bench for byte_alu_exec: directed corner cases plus seeded random opcodes,
// checked against a register model kept in the bench.
module tb_byte_alu_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = 16'h0000;
    logic        rnd_force_ones = 1'b0;
    logic [3:0]  rd_a_addr = 4'd0, rd_b_addr = 4'd1;
    logic [7:0]  rd_a_data, rd_b_data;
    logic        done, illegal;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m [16];
    logic [7:0] rng_m;

    always #5 clk = ~clk;

    byte_alu_exec dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .rnd_force_ones(rnd_force_ones),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .done(done), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // R12: compare every register through the two read ports.
    task automatic chk_regs(input string tag);
        logic bad = 1'b0;
        for (int r = 0; r < 16; r += 2) begin
            rd_a_addr = 4'(r);
            rd_b_addr = 4'(r + 1);
            #1;
            if (rd_a_data !== m[r] || rd_b_data !== m[r+1]) begin
                bad = 1'b1;
                $display("FAIL %s R12: V%0h/V%0h got %h/%h expected %h/%h",
                         tag, r, r + 1, rd_a_data, rd_b_data, m[r], m[r+1]);
            end
        end
        checks++;
        if (bad) fails++;
    endtask

    // Model update; returns 1 when the opcode is undefined (R10).
    function automatic logic model(input logic [15:0] op, input logic frc);
        logic [3:0] x = op[11:8];
        logic [3:0] y = op[7:4];
        logic [7:0] a = m[op[11:8]];
        logic [7:0] b = m[op[7:4]];
        logic [8:0] s;
        logic [7:0] byt;
        if (op[15:12] == 4'hC) begin
            byt = frc ? 8'hFF : rng_m;
            m[x] = byt & op[7:0];
            rng_m = {rng_m[6:0], rng_m[7] ^ rng_m[5] ^ rng_m[4] ^ rng_m[3]};
            return 1'b0;
        end
        if (op[15:12] != 4'h8) return 1'b1;
        case (op[3:0])
            4'h0: m[x] = b;
            4'h1: m[x] = a | b;
            4'h2: m[x] = a & b;
            4'h3: m[x] = a ^ b;
            4'h4: begin s = {1'b0, a} + {1'b0, b}; m[x] = s[7:0]; m[15] = {7'd0, s[8]}; end
            4'h5: begin m[x] = a - b; m[15] = (a >= b) ? 8'd1 : 8'd0; end
            4'h7: begin m[x] = b - a; m[15] = (b >= a) ? 8'd1 : 8'd0; end
            4'h6: begin m[x] = a >> 1; m[15] = {7'd0, a[0]}; end
            4'hE: begin m[x] = a << 1; m[15] = {7'd0, a[7]}; end
            default: return 1'b1;
        endcase
        if (y == 4'hF && x == 4'hF) return 1'b0;
        return 1'b0;
    endfunction

    // R2: strobe one opcode, check done/illegal and all registers after commit.
    task automatic run_op(input logic [15:0] op, input logic frc, input string tag);
        logic exp_ill;
        @(negedge clk);
        op_valid = 1'b1; opcode = op; rnd_force_ones = frc;
        @(negedge clk);
        op_valid = 1'b0; rnd_force_ones = 1'b0;
        exp_ill = model(op, frc);
        @(negedge clk);
        chk({tag, " R2 done"}, 32'(done), 32'd1);
        chk({tag, " R10 illegal"}, 32'(illegal), 32'(exp_ill));
        chk_regs(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m[i] = 8'h00;
        rng_m = 8'h01;
        repeat (3) @(negedge clk);
        chk("R1 done at reset", 32'(done), 32'd0);
        chk("R1 illegal at reset", 32'(illegal), 32'd0);
        rst_n = 1'b1;
        chk_regs("R1 reset state");

        // R8: same-register add
        run_op(16'hC3B4, 1'b1, "R9 force load");
        run_op(16'h8334, 1'b0, "R8 v3+=v3");
        chk("R8 V15 after v3+=v3", 32'(m[15]), 32'h01);
        // R7: destination is the flag register
        run_op(16'hCF84, 1'b1, "R9 load VF");
        run_op(16'h8F34, 1'b0, "R7 VF+=V3 no carry");
        run_op(16'hCFDA, 1'b1, "R9 load VF");
        run_op(16'h8F34, 1'b0, "R7 VF+=V3 carry");
        run_op(16'hCF83, 1'b1, "R9 load VF");
        run_op(16'h8FF6, 1'b0, "R6 R7 VF>>=1");
        run_op(16'hCF84, 1'b1, "R9 load VF");
        run_op(16'h8FFE, 1'b0, "R6 R7 VF<<=1");
        // R5: subtract forms with the flag register as destination
        run_op(16'hC133, 1'b1, "R9 load V1");
        run_op(16'hCF84, 1'b1, "R9 load VF");
        run_op(16'h8F15, 1'b0, "R5 VF-=V1 no borrow");
        run_op(16'hCF30, 1'b1, "R9 load VF");
        run_op(16'h8F15, 1'b0, "R5 VF-=V1 borrow");
        run_op(16'hC3CF, 1'b1, "R9 load V3");
        run_op(16'hCF84, 1'b1, "R9 load VF");
        run_op(16'h8F37, 1'b0, "R5 VF=V3-VF");
        run_op(16'h8567, 1'b0, "R5 subn equal zeros");
        // R3: logic ops leave the flag alone
        run_op(16'hC2F0, 1'b1, "R9 load V2");
        run_op(16'h8231, 1'b0, "R3 or");
        run_op(16'h8232, 1'b0, "R3 and");
        run_op(16'h8233, 1'b0, "R3 xor");
        run_op(16'h8420, 1'b0, "R3 mov");
        // R9: generator value, unmasked
        run_op(16'hC0FF, 1'b0, "R9 rng byte");
        run_op(16'hC0FF, 1'b0, "R9 rng byte next");
        // R10: undefined opcodes
        run_op(16'h8128, 1'b0, "R10 group8 N=8");
        run_op(16'h812F, 1'b0, "R10 group8 N=F");
        run_op(16'h0123, 1'b0, "R10 other group");

        // R11: strobe held for two cycles executes once
        @(negedge clk);
        op_valid = 1'b1; opcode = 16'h8224;
        @(negedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        void'(model(16'h8224, 1'b0));
        chk("R11 first done", 32'(done), 32'd1);
        @(negedge clk);
        chk("R11 no second done", 32'(done), 32'd0);
        chk_regs("R11 single execution");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] nsel [9] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE};
            int k = $urandom % 10;
            logic [15:0] op;
            logic frc = 1'b0;
            if (k < 3) begin
                op = {4'hC, 4'($urandom), 8'($urandom)};
                frc = ($urandom % 8) == 0;
            end else if (k < 9) begin
                op = {4'h8, 4'($urandom), 4'($urandom), nsel[$urandom % 9]};
            end else begin
                op = 16'($urandom);
                if (op[15:12] == 4'h8) op[3:0] = 4'h9;
            end
            run_op(op, frc, "random R3 R4 R5 R6 R9");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule